// File: doc/BRIEF.md
# PCI Interrupt Router and Trigger Shaper

This block takes an interrupt event raised by a PCI device, identified by its slot number and by which of its four interrupt pins (A to D, numbered 0 to 3) fired. It turns that pair into an internal interrupt line number through a fixed slot table. The table has one slot whose four pins keep their own lines, two slots whose pins all share one line each, and a run of expansion slots whose pin assignment rotates with the slot. Slots outside the table are not translated. The line number is reported on the cycle after the event.

For lines that fall inside the window of 32 internal lines, two configuration vectors indexed by the internal line (line minus the base) set the shape of the CPU interrupt. One vector selects pulse mode, which gives a single-cycle high pulse. The other selects the level driven when pulse mode is off, and that level is held until the next accepted event. Lines outside the window are reported with an out-of-range flag and leave the CPU interrupt alone.

Top module: `irq_router`

## Requirements
- R1: After synchronous active-low reset, `cpu_irq`, `line_valid`, `line_oor` are 0 and `line_num` is 0.
- R2: An event from slot 5 maps to line 32 + pin.
- R3: An event from slot 6 maps to line 36 and one from slot 7 to line 37, for every pin.
- R4: An event from slots 8 to 12 maps to line (slot − 8) + pin + 38.
- R5: An event from any other slot reports line = pin, sets `line_oor`, and leaves `cpu_irq` at its previous held level.
- R6: `line_valid` is high in exactly the cycle after a cycle with `evt_valid` high, and `line_num` and `line_oor` are valid then.
- R7: For an in-range line whose bit in `edge_sel` (bit = line − 32) was 1 at the event, `cpu_irq` is high for exactly the one cycle after the event and low afterwards.
- R8: For an in-range line whose `edge_sel` bit was 0, `cpu_irq` takes the value of that line's `pol_sel` bit from the cycle after the event and keeps it until the next in-range event.
- R9: `edge_sel` and `pol_sel` are sampled only in an event cycle; changing them at other times does not change `cpu_irq`.
- R10: `cpu_irq` never rises except in the cycle after an event that maps to an in-range line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Interrupt event strobe |
| evt_slot | input | 5 | Slot of the interrupting device |
| evt_pin | input | 2 | Interrupt pin 0..3 (A..D) |
| edge_sel | input | 32 | Per internal line: 1 = pulse output |
| pol_sel | input | 32 | Per internal line: level driven when not pulsed |
| line_valid | output | 1 | Mapped line report valid |
| line_num | output | 8 | Mapped interrupt line number |
| line_oor | output | 1 | Mapped line lies outside the internal window |
| cpu_irq | output | 1 | Shaped CPU interrupt |

## Verification
On every cycle the assertions check these properties: the report strobe follows the event one cycle later, the two fixed slots map to their constant lines, pulse-mode lines give a one-cycle high, level-mode lines show the selected polarity, and the interrupt never rises without an in-range report. Some behaviours can only be shown by the bench's scenarios. These are the exact line numbers for the rotating expansion slots and for pass-through slots, a held level that survives later out-of-range events and configuration changes, and the reset values.

// File: rtl/irq_route_pkg.sv
// Package: shared widths and slot-table constants for the interrupt router.
package irq_route_pkg;
    localparam int SLOT_W      = 5;   // slot number width
    localparam int PIN_W       = 2;   // interrupt pin width (A..D)
    localparam int LINE_W      = 8;   // mapped line number width
    localparam int LINE_BASE   = 32;  // first internal line number
    localparam int NUM_LINES   = 32;  // size of the internal line window
    localparam int QUAD_SLOT   = 5;   // slot whose pins keep separate lines
    localparam int SOLO_SLOT_A = 6;   // slot with one shared line
    localparam int SOLO_SLOT_B = 7;   // second slot with one shared line
    localparam int EXP_FIRST   = 8;   // first rotating expansion slot
    localparam int EXP_COUNT   = 5;   // number of expansion slots
    localparam int SOLO_OFS_A  = 4;   // line offset for SOLO_SLOT_A
    localparam int SOLO_OFS_B  = 5;   // line offset for SOLO_SLOT_B
    localparam int EXP_OFS     = 6;   // line offset of expansion group
endpackage

// File: rtl/irq_slot_map.sv
// Module: irq_slot_map
// Purely combinational slot/pin to line translation.
// Assumes the expansion group lies above the fixed slots; any slot not
// listed passes its pin number through untranslated.
module irq_slot_map
    import irq_route_pkg::*;
#(
    parameter int SW        = SLOT_W,
    parameter int PW        = PIN_W,
    parameter int LW        = LINE_W,
    parameter int BASE      = LINE_BASE,
    parameter int EXP_FIRST_P = EXP_FIRST,
    parameter int EXP_CNT_P   = EXP_COUNT
) (
    input  logic [SW-1:0] slot,
    input  logic [PW-1:0] pin,
    output logic [LW-1:0] line
);
    localparam logic [SW-1:0] QUAD_S  = SW'(QUAD_SLOT);
    localparam logic [SW-1:0] SOLO_SA = SW'(SOLO_SLOT_A);
    localparam logic [SW-1:0] SOLO_SB = SW'(SOLO_SLOT_B);
    localparam logic [SW-1:0] EXP_LO  = SW'(EXP_FIRST_P);
    localparam logic [SW:0]   EXP_HI  = (SW+1)'(EXP_FIRST_P + EXP_CNT_P);
    localparam logic [LW-1:0] BASE_L  = LW'(BASE);

    logic in_exp;

    // Purpose: detect membership in the rotating expansion group.
    always_comb in_exp = (slot >= EXP_LO) && ({1'b0, slot} < EXP_HI);

    // Purpose: select the line number for the current slot/pin pair.
    always_comb begin
        if (slot == QUAD_S)
            line = BASE_L + LW'(pin);
        else if (slot == SOLO_SA)
            line = BASE_L + LW'(SOLO_OFS_A);
        else if (slot == SOLO_SB)
            line = BASE_L + LW'(SOLO_OFS_B);
        else if (in_exp)
            line = BASE_L + LW'(EXP_OFS) + LW'(slot - EXP_LO) + LW'(pin);
        else
            line = LW'(pin);
    end
endmodule

// File: rtl/irq_line_decode.sv
// Module: irq_line_decode
// Checks that a line lies in the internal window and picks that line's
// pulse-select and polarity bits through a one-hot decode.
// Assumes NUM is a power of two no larger than 2**LW.
module irq_line_decode #(
    parameter int LW   = 8,
    parameter int BASE = 32,
    parameter int NUM  = 32
) (
    input  logic [LW-1:0]  line,
    input  logic [NUM-1:0] edge_vec,
    input  logic [NUM-1:0] pol_vec,
    output logic           in_range,
    output logic           edge_bit,
    output logic           pol_bit
);
    localparam int IW = $clog2(NUM);
    localparam logic [LW:0] LO_L = (LW+1)'(BASE);
    localparam logic [LW:0] HI_L = (LW+1)'(BASE + NUM);

    logic [IW-1:0]  idx;
    logic [NUM-1:0] hit;

    // Purpose: window test and line-to-index conversion.
    always_comb begin
        in_range = ({1'b0, line} >= LO_L) && ({1'b0, line} < HI_L);
        idx      = IW'(line - LW'(BASE));
    end

    // Purpose: one decoder leg per internal line.
    for (genvar i = 0; i < NUM; i++) begin : g_hit
        assign hit[i] = in_range && (idx == IW'(i));
    end

    // Purpose: pick the configuration bits of the hit line.
    always_comb begin
        edge_bit = |(hit & edge_vec);
        pol_bit  = |(hit & pol_vec);
    end
endmodule

// File: rtl/irq_shaper.sv
// Module: irq_shaper
// Produces the CPU interrupt: a one-cycle pulse or a held level.
// Assumes accept is high only for events that map inside the window.
module irq_shaper (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic edge_bit,
    input  logic pol_bit,
    output logic irq
);
    logic pulse_q;
    logic level_q;

    // Purpose: pulse lasts one cycle; level updates only on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            level_q <= 1'b0;
        end else begin
            pulse_q <= accept && edge_bit;
            if (accept)
                level_q <= edge_bit ? 1'b0 : pol_bit;
        end
    end

    // Purpose: merge the pulse and the held level.
    always_comb irq = pulse_q | level_q;
endmodule

// File: rtl/irq_router.sv
// Module: irq_router (top)
// Maps a PCI slot/pin event to an interrupt line, reports it one cycle
// later and shapes the CPU interrupt from per-line configuration.
// Assumes configuration vectors are only meaningful in event cycles.
module irq_router
    import irq_route_pkg::*;
#(
    parameter int SW   = SLOT_W,
    parameter int PW   = PIN_W,
    parameter int LW   = LINE_W,
    parameter int BASE = LINE_BASE,
    parameter int NUM  = NUM_LINES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_valid,
    input  logic [SW-1:0] evt_slot,
    input  logic [PW-1:0] evt_pin,
    input  logic [NUM-1:0] edge_sel,
    input  logic [NUM-1:0] pol_sel,
    output logic          line_valid,
    output logic [LW-1:0] line_num,
    output logic          line_oor,
    output logic          cpu_irq
);
    logic [LW-1:0] map_line;
    logic          map_in_range;
    logic          map_edge;
    logic          map_pol;
    logic          accept;

    irq_slot_map #(
        .SW(SW), .PW(PW), .LW(LW), .BASE(BASE),
        .EXP_FIRST_P(EXP_FIRST), .EXP_CNT_P(EXP_COUNT)
    ) map_i (
        .slot (evt_slot),
        .pin  (evt_pin),
        .line (map_line)
    );

    irq_line_decode #(.LW(LW), .BASE(BASE), .NUM(NUM)) dec_i (
        .line     (map_line),
        .edge_vec (edge_sel),
        .pol_vec  (pol_sel),
        .in_range (map_in_range),
        .edge_bit (map_edge),
        .pol_bit  (map_pol)
    );

    // Purpose: only in-window events may change the interrupt.
    always_comb accept = evt_valid && map_in_range;

    irq_shaper shp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .edge_bit (map_edge),
        .pol_bit  (map_pol),
        .irq      (cpu_irq)
    );

    // Purpose: register the line report for the cycle after the event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_valid <= 1'b0;
            line_num   <= '0;
            line_oor   <= 1'b0;
        end else begin
            line_valid <= evt_valid;
            if (evt_valid) begin
                line_num <= map_line;
                line_oor <= !map_in_range;
            end
        end
    end
endmodule

// File: rtl/irq_router_chk.sv
// Module: irq_router_chk
// Property checker bound to irq_router; keeps its own copy of the event
// configuration to relate reports to the interrupt output.
module irq_router_chk
    import irq_route_pkg::*;
#(
    parameter int SW   = SLOT_W,
    parameter int PW   = PIN_W,
    parameter int LW   = LINE_W,
    parameter int BASE = LINE_BASE,
    parameter int NUM  = NUM_LINES
) (
    input logic           clk,
    input logic           rst_n,
    input logic           evt_valid,
    input logic [SW-1:0]  evt_slot,
    input logic [PW-1:0]  evt_pin,
    input logic [NUM-1:0] edge_sel,
    input logic [NUM-1:0] pol_sel,
    input logic           line_valid,
    input logic [LW-1:0]  line_num,
    input logic           line_oor,
    input logic           cpu_irq
);
    localparam int IW = $clog2(NUM);

    logic [SW-1:0]  slot_d;
    logic [NUM-1:0] edge_d;
    logic [NUM-1:0] pol_d;
    logic [IW-1:0]  idx_c;

    // Purpose: capture event-cycle inputs for next-cycle comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_d <= '0;
            edge_d <= '0;
            pol_d  <= '0;
        end else begin
            slot_d <= evt_slot;
            edge_d <= edge_sel;
            pol_d  <= pol_sel;
        end
    end

    // Purpose: internal index of the reported line.
    always_comb idx_c = IW'(line_num - LW'(BASE));

    a_r6_report_follows: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> line_valid);
    a_r6_no_report: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |=> !line_valid);
    a_r3_solo_slots: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && (slot_d == SW'(SOLO_SLOT_A))) |-> (line_num == LW'(BASE + SOLO_OFS_A)));
    a_r3_solo_slot_b: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && (slot_d == SW'(SOLO_SLOT_B))) |-> (line_num == LW'(BASE + SOLO_OFS_B)));
    a_r7_pulse_high: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !line_oor && edge_d[idx_c]) |-> cpu_irq);
    a_r7_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !line_oor && edge_d[idx_c]) |=> (!cpu_irq || line_valid));
    a_r8_level_pol: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !line_oor && !edge_d[idx_c]) |-> (cpu_irq == pol_d[idx_c]));
    a_r5_oor_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && line_oor) |-> !$rose(cpu_irq));
    a_r10_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> (line_valid && !line_oor));
endmodule

bind irq_router irq_router_chk #(
    .SW(SW), .PW(PW), .LW(LW), .BASE(BASE), .NUM(NUM)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .evt_slot   (evt_slot),
    .evt_pin    (evt_pin),
    .edge_sel   (edge_sel),
    .pol_sel    (pol_sel),
    .line_valid (line_valid),
    .line_num   (line_num),
    .line_oor   (line_oor),
    .cpu_irq    (cpu_irq)
);

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [4:0]  evt_slot = '0;
    logic [1:0]  evt_pin = '0;
    logic [31:0] edge_sel = '0;
    logic [31:0] pol_sel = '0;
    logic        line_valid;
    logic [7:0]  line_num;
    logic        line_oor;
    logic        cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit level_m = 1'b0;   // model of the held level

    always #10 clk = ~clk;  // 50 MHz

    irq_router dut_i (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid),
        .evt_slot(evt_slot), .evt_pin(evt_pin),
        .edge_sel(edge_sel), .pol_sel(pol_sel),
        .line_valid(line_valid), .line_num(line_num),
        .line_oor(line_oor), .cpu_irq(cpu_irq)
    );

    // Expected line per the requirements R2..R5.
    function automatic int exp_line(int slot, int pin);
        if (slot == 5)                   return 32 + pin;
        if (slot == 6)                   return 36;
        if (slot == 7)                   return 37;
        if (slot >= 8 && slot <= 12)     return (slot - 8) + pin + 38;
        return pin;
    endfunction

    function automatic string req_of(int slot);
        if (slot == 5)               return "R2";
        if (slot == 6 || slot == 7)  return "R3";
        if (slot >= 8 && slot <= 12) return "R4";
        return "R5";
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One event, then one idle cycle; configuration is scrambled while idle (R9).
    task automatic send(int slot, int pin, logic [31:0] e, logic [31:0] p);
        int  ln;
        bit  inr;
        bit  exp_irq1;
        ln  = exp_line(slot, pin);
        inr = (ln >= 32) && (ln < 64);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_slot  = 5'(slot);
        evt_pin   = 2'(pin);
        edge_sel  = e;
        pol_sel   = p;
        @(negedge clk);
        evt_valid = 1'b0;
        edge_sel  = ~e;
        pol_sel   = ~p;
        if (inr) begin
            if (e[ln-32]) begin exp_irq1 = 1'b1; level_m = 1'b0; end
            else begin level_m = p[ln-32]; exp_irq1 = level_m; end
        end else exp_irq1 = level_m;
        check("R6", "line_valid", int'(line_valid), 1);
        check(req_of(slot), "line_num", int'(line_num), ln);
        check(inr ? "R6" : "R5", "line_oor", int'(line_oor), inr ? 0 : 1);
        check(inr ? (e[ln-32] ? "R7" : "R8") : "R5", "irq after event",
              int'(cpu_irq), int'(exp_irq1));
        @(negedge clk);
        check("R6", "line_valid idle", int'(line_valid), 0);
        check(inr && e[ln-32] ? "R7" : "R9", "irq held", int'(cpu_irq), int'(level_m));
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20241);
        repeat (3) @(negedge clk);
        check("R1", "cpu_irq", int'(cpu_irq), 0);
        check("R1", "line_valid", int'(line_valid), 0);
        check("R1", "line_oor", int'(line_oor), 0);
        check("R1", "line_num", int'(line_num), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "irq without event", int'(cpu_irq), 0);
        // Directed table corners.
        for (int p = 0; p < 4; p++) send(5, p, 32'h0, 32'hFFFF_FFFF);
        send(6, 3, 32'h0, 32'h0);
        send(7, 0, 32'h0, 32'h20);
        send(8, 0, 32'h0, 32'h40);
        send(12, 3, 32'h0, 32'h0);
        send(10, 2, 32'h0, 32'h800);
        // Pulse mode, then level high, then out-of-range keeps level (R5).
        send(5, 1, 32'h2, 32'h2);
        send(6, 0, 32'h0, 32'h10);
        send(4, 2, 32'hFFFF_FFFF, 32'h0);
        send(13, 1, 32'h0, 32'h0);
        send(0, 3, 32'h0, 32'h0);
        send(31, 0, 32'hFFFF_FFFF, 32'h0);
        // Pulse from a high held level: pulse then low (R7).
        send(9, 1, 32'h100, 32'h0);
        // Random mix.
        for (int i = 0; i < 400; i++)
            send(int'($urandom_range(0, 15)), int'($urandom_range(0, 3)),
                 $urandom(), $urandom());
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule